// File: doc/BRIEF.md
# Multichannel Playback Sample Conditioner

This block sits between the playback sample stream and a bank of resistor-ladder DACs. Each accepted sample is a signed 16-bit value tagged with one of eight speaker channels: front L/R, centre, subwoofer, surround L/R and side L/R, numbered 0 to 7 in that order. The block scales the sample by a per-channel linear attenuation code and applies the channel mute. When the sample belongs to the pair that feeds the stereo headphone, it also produces a headphone copy on a second output lane. Each result is re-coded as a 17-bit unsigned DAC word: offset binary plus a fixed bias of 64.

A jack-sense override covers the case where no host driver is present and a headphone is plugged in. In that case every speaker channel falls silent and the headphone always listens to the front pair. With interpolation enabled, every input produces two words per lane on consecutive cycles. The first is the mean of this sample and the previous sample of the same lane. The second is the sample itself. This doubles the conversion rate.

Top module: `pbc_conditioner`

## Requirements
- R1: After reset, both valid outputs are low and both output words are 0. Every history entry reads as 0, so the first interpolated word of a channel averages the new sample with zero.
- R2: The output word is the processed signed sample plus 32768 plus 64. So -32768 gives 64, 0 gives 32832, -1 gives 32831 and 32767 gives 65599.
- R3: The 6-bit volume code for channel c sits in bits [6c+5:6c] of the volume vector. For code k below 37 the gain word is g = floor((1024*(36000-994k)+18000)/36000): code 0 gives 1024 and code 36 gives 6. The processed sample is floor(sample*g/1024).
- R4: Any volume code of 37 or more gives a gain of zero, so the processed sample is 0 and the word is 32832.
- R5: Mute bit c (0..7) forces the speaker-lane sample of channel c to zero. The bit order is front L, front R, centre, sub, surround L, surround R, side L, side R.
- R6: The headphone select value p (0 front, 1 centre/sub, 2 surround, 3 side) picks channels 2p and 2p+1. Their samples, scaled by their own volume code, also leave on the headphone lane, with tag 0 for the even channel and 1 for the odd channel. Mute bits 8 and 9 mute the headphone left and right copies.
- R7: When jack sense is high and driver-present is low, every speaker-lane sample is zero. The headphone lane takes channels 0 and 1 whatever the select value, and mute bits 8 and 9 are ignored. With driver-present high, the mute mask and the select value apply.
- R8: With interpolation off, a sample accepted at clock edge t yields exactly one word per active lane, valid after edge t+2. Inputs may arrive on every cycle.
- R9: With interpolation on, the lane emits floor((previous+current)/2) after edge t+2 and the current sample after edge t+3, with the same tag. Such an input must be followed by at least one idle cycle.
- R10: Each history entry is private to its lane and channel (8 speaker entries, 2 headphone entries). It is updated by every sample processed, with or without interpolation, and muted samples store zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample accepted this cycle |
| in_chan | input | 3 | Speaker channel of the sample |
| in_sample | input | 16 | Signed sample |
| vol_codes | input | 48 | Six-bit attenuation code per channel |
| mute_mask | input | 10 | Per-channel mute, bits 8/9 headphone |
| hp_sel | input | 2 | Headphone source pair |
| driver_on | input | 1 | Host driver present |
| jack_sense | input | 1 | Headphone plugged in |
| interp_en | input | 1 | Double-rate interpolation enable |
| out_valid | output | 1 | Speaker-lane word valid |
| out_chan | output | 3 | Speaker-lane channel tag |
| out_word | output | 17 | Speaker-lane DAC word |
| hp_valid | output | 1 | Headphone-lane word valid |
| hp_chan | output | 1 | Headphone tag, 0 left 1 right |
| hp_word | output | 17 | Headphone-lane DAC word |

## Verification
The full-scale extremes, zero and minus one are sent at unity gain. These separate a correct sign flip and bias from an off-by-one or a missing bias. Unity, mid and near-silent codes, the first mute code and codes above it are sent on different channels. These show whether the gain table is indexed by the right channel's field. The mute masks, each headphone select value and the jack override with both driver states are tried on all eight channels, so that a misrouted pair or a mask bit taken from the wrong position becomes visible. Interpolated runs on interleaved channels are mixed with non-interpolated ones, and a mid-run reset is included. These show whether history is kept per channel and whether it starts from zero.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int SAMPLE_W = 16;
  localparam int WORD_W   = SAMPLE_W + 1;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic [WORD_W-1:0]          dac_word_t;

  // Linear attenuation: unity at code 0 and about 0.006 at the last code
  // below the mute code, expressed in units of 2**frac.
  function automatic int lin_gain(int code, int frac, int mute_code);
    int span;
    if (code >= mute_code) return 0;
    span = mute_code - 1;
    return ((1 << frac) * (1000 * span - 994 * code) + 500 * span) / (1000 * span);
  endfunction

  // Signed sample to offset binary, then a fixed bias on top.
  function automatic dac_word_t to_dac(sample_t s, int bias);
    dac_word_t u;
    u = {1'b0, ~s[SAMPLE_W-1], s[SAMPLE_W-2:0]};
    return u + WORD_W'(bias);
  endfunction
endpackage

// File: rtl/pbc_gain_lane.sv
module pbc_gain_lane #(
  parameter int FRAC  = 10,
  parameter int TAG_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic                  mute,
  input  logic [FRAC:0]         gain,
  input  pbc_pkg::sample_t      din,
  input  logic [TAG_W-1:0]      tag_in,
  input  logic                  interp_in,
  output logic                  vld,
  output pbc_pkg::sample_t      dout,
  output logic [TAG_W-1:0]      tag_out,
  output logic                  interp_out
);
  localparam int SW = pbc_pkg::SAMPLE_W;
  localparam int PW = SW + FRAC + 2;
  localparam logic signed [PW-1:0] HI = PW'((2 ** (SW - 1)) - 1);
  localparam logic signed [PW-1:0] LO = -HI - 1;

  logic signed [PW-1:0] prod, scaled;
  pbc_pkg::sample_t     clipped;

  always_comb begin
    prod   = din * $signed({1'b0, gain});
    scaled = prod >>> FRAC;
    if (scaled > HI)      clipped = HI[SW-1:0];
    else if (scaled < LO) clipped = LO[SW-1:0];
    else                  clipped = scaled[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld        <= 1'b0;
      dout       <= '0;
      tag_out    <= '0;
      interp_out <= 1'b0;
    end else begin
      vld <= take;
      if (take) begin
        dout       <= mute ? '0 : clipped;
        tag_out    <= tag_in;
        interp_out <= interp_in;
      end
    end
  end
endmodule

// File: rtl/pbc_interp_lane.sv
module pbc_interp_lane #(
  parameter int TAG_W = 3,
  parameter int BIAS  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld,
  input  pbc_pkg::sample_t   smp,
  input  logic [TAG_W-1:0]   tag,
  input  logic               interp,
  output logic               ovld,
  output logic [TAG_W-1:0]   otag,
  output pbc_pkg::dac_word_t oword
);
  localparam int SW    = pbc_pkg::SAMPLE_W;
  localparam int DEPTH = 2 ** TAG_W;

  pbc_pkg::sample_t   hist [DEPTH];
  logic [DEPTH-1:0]   seen;
  pbc_pkg::sample_t   prev, avg;
  logic signed [SW:0] sum;
  logic               pend_v;
  pbc_pkg::dac_word_t pend_w;
  logic [TAG_W-1:0]   pend_t;

  always_comb begin
    prev = seen[tag] ? hist[tag] : '0;
    sum  = $signed({prev[SW-1], prev}) + $signed({smp[SW-1], smp});
    avg  = sum[SW:1];
  end

  // History store has no reset so it maps onto RAM; the seen bits stand in.
  always_ff @(posedge clk) begin
    if (vld) hist[tag] <= smp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen   <= '0;
      ovld   <= 1'b0;
      otag   <= '0;
      oword  <= '0;
      pend_v <= 1'b0;
      pend_w <= '0;
      pend_t <= '0;
    end else begin
      pend_v <= vld & interp;
      if (vld) begin
        seen[tag] <= 1'b1;
        ovld      <= 1'b1;
        otag      <= tag;
        oword     <= pbc_pkg::to_dac(interp ? avg : smp, BIAS);
        pend_w    <= pbc_pkg::to_dac(smp, BIAS);
        pend_t    <= tag;
      end else if (pend_v) begin
        ovld  <= 1'b1;
        otag  <= pend_t;
        oword <= pend_w;
      end else begin
        ovld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pbc_conditioner.sv
module pbc_conditioner #(
  parameter int NUM_CH    = 8,
  parameter int VOL_W     = 6,
  parameter int GAIN_FRAC = 10,
  parameter int MUTE_CODE = 37,
  parameter int DAC_BIAS  = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [$clog2(NUM_CH)-1:0]     in_chan,
  input  logic [pbc_pkg::SAMPLE_W-1:0]  in_sample,
  input  logic [NUM_CH*VOL_W-1:0]       vol_codes,
  input  logic [NUM_CH+1:0]             mute_mask,
  input  logic [$clog2(NUM_CH)-2:0]     hp_sel,
  input  logic                          driver_on,
  input  logic                          jack_sense,
  input  logic                          interp_en,
  output logic                          out_valid,
  output logic [$clog2(NUM_CH)-1:0]     out_chan,
  output logic [pbc_pkg::WORD_W-1:0]    out_word,
  output logic                          hp_valid,
  output logic                          hp_chan,
  output logic [pbc_pkg::WORD_W-1:0]    hp_word
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int GW     = GAIN_FRAC + 1;
  localparam int VCODES = 2 ** VOL_W;

  logic [GW-1:0]    gain_rom [VCODES];
  logic [VOL_W-1:0] code;
  logic [GW-1:0]    gain;
  logic             override, hp_hit, main_mute, hp_mute;
  logic [CH_W-2:0]  hp_src;

  for (genvar c = 0; c < VCODES; c++) begin : g_gain_rom
    assign gain_rom[c] = GW'(pbc_pkg::lin_gain(c, GAIN_FRAC, MUTE_CODE));
  end

  always_comb begin
    code      = vol_codes[in_chan*VOL_W +: VOL_W];
    gain      = gain_rom[code];
    override  = jack_sense & ~driver_on;
    hp_src    = override ? '0 : hp_sel;
    hp_hit    = (in_chan[CH_W-1:1] == hp_src);
    main_mute = override | mute_mask[in_chan];
    hp_mute   = ~override & mute_mask[NUM_CH + 32'(in_chan[0])];
  end

  pbc_pkg::sample_t m_s, h_s;
  logic             m_v, h_v, m_i, h_i;
  logic [CH_W-1:0]  m_t;
  logic [0:0]       h_t, h_tag_out;

  pbc_gain_lane #(.FRAC(GAIN_FRAC), .TAG_W(CH_W)) i_gain_main (
    .clk(clk), .rst(rst), .take(in_valid), .mute(main_mute), .gain(gain),
    .din(in_sample), .tag_in(in_chan), .interp_in(interp_en),
    .vld(m_v), .dout(m_s), .tag_out(m_t), .interp_out(m_i));

  pbc_gain_lane #(.FRAC(GAIN_FRAC), .TAG_W(1)) i_gain_hp (
    .clk(clk), .rst(rst), .take(in_valid & hp_hit), .mute(hp_mute), .gain(gain),
    .din(in_sample), .tag_in(in_chan[0]), .interp_in(interp_en),
    .vld(h_v), .dout(h_s), .tag_out(h_t), .interp_out(h_i));

  pbc_interp_lane #(.TAG_W(CH_W), .BIAS(DAC_BIAS)) i_out_main (
    .clk(clk), .rst(rst), .vld(m_v), .smp(m_s), .tag(m_t), .interp(m_i),
    .ovld(out_valid), .otag(out_chan), .oword(out_word));

  pbc_interp_lane #(.TAG_W(1), .BIAS(DAC_BIAS)) i_out_hp (
    .clk(clk), .rst(rst), .vld(h_v), .smp(h_s), .tag(h_t), .interp(h_i),
    .ovld(hp_valid), .otag(h_tag_out), .oword(hp_word));

  assign hp_chan = h_tag_out[0];
endmodule

// File: rtl/pbc_conditioner_chk.sv
module pbc_conditioner_chk #(
  parameter int NUM_CH    = 8,
  parameter int VOL_W     = 6,
  parameter int MUTE_CODE = 37,
  parameter int DAC_BIAS  = 64
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic [$clog2(NUM_CH)-1:0]    in_chan,
  input logic [NUM_CH*VOL_W-1:0]      vol_codes,
  input logic [$clog2(NUM_CH)-2:0]    hp_sel,
  input logic                         driver_on,
  input logic                         jack_sense,
  input logic                         interp_en,
  input logic                         out_valid,
  input logic [$clog2(NUM_CH)-1:0]    out_chan,
  input logic [pbc_pkg::WORD_W-1:0]   out_word,
  input logic                         hp_valid,
  input logic                         hp_chan
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [pbc_pkg::WORD_W-1:0] MID = pbc_pkg::WORD_W'(2 ** (pbc_pkg::SAMPLE_W - 1) + DAC_BIAS);
  localparam logic [pbc_pkg::WORD_W-1:0] TOP = pbc_pkg::WORD_W'(2 ** pbc_pkg::SAMPLE_W - 1 + DAC_BIAS);

  logic [VOL_W-1:0] cur_code;
  logic             ovr;
  assign cur_code = vol_codes[in_chan*VOL_W +: VOL_W];
  assign ovr      = jack_sense & ~driver_on;

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid && !hp_valid);

  p_word_range_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word >= pbc_pkg::WORD_W'(DAC_BIAS)) && (out_word <= TOP));

  p_mute_code_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && !interp_en && (32'(cur_code) >= MUTE_CODE) |=> ##1 out_word == MID);

  p_hp_select_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && !ovr && (in_chan[CH_W-1:1] == hp_sel) |=> ##1 hp_valid && (hp_chan == $past(in_chan[0], 2)));

  p_override_mute_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && ovr && !interp_en |=> ##1 out_valid && out_word == MID);

  p_override_hp_front_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && ovr && (in_chan[CH_W-1:1] != '0) |=> ##1 !hp_valid);

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid && (out_chan == $past(in_chan, 2)));

  p_second_word_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && interp_en |=> ##2 out_valid && (out_chan == $past(in_chan, 3)));

  p_input_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && interp_en |=> !in_valid);
endmodule

bind pbc_conditioner pbc_conditioner_chk #(
  .NUM_CH(NUM_CH), .VOL_W(VOL_W), .MUTE_CODE(MUTE_CODE), .DAC_BIAS(DAC_BIAS)
) i_pbc_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
  .vol_codes(vol_codes), .hp_sel(hp_sel), .driver_on(driver_on),
  .jack_sense(jack_sense), .interp_en(interp_en), .out_valid(out_valid),
  .out_chan(out_chan), .out_word(out_word), .hp_valid(hp_valid), .hp_chan(hp_chan)
);

// File: tb/test_pbc_conditioner.sv
module test_pbc_conditioner;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_chan = '0;
  logic [15:0] in_sample = '0;
  logic [47:0] vol_codes = '0;
  logic [9:0]  mute_mask = '0;
  logic [1:0]  hp_sel = '0;
  logic        driver_on = 1'b1;
  logic        jack_sense = 1'b0;
  logic        interp_en = 1'b0;
  logic        out_valid, hp_valid, hp_chan;
  logic [2:0]  out_chan;
  logic [16:0] out_word, hp_word;

  pbc_conditioner i_pbc_conditioner (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_sample(in_sample),
    .vol_codes(vol_codes), .mute_mask(mute_mask), .hp_sel(hp_sel), .driver_on(driver_on),
    .jack_sense(jack_sense), .interp_en(interp_en), .out_valid(out_valid), .out_chan(out_chan),
    .out_word(out_word), .hp_valid(hp_valid), .hp_chan(hp_chan), .hp_word(hp_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int due; int tag; int word; } exp_t;
  exp_t  qm[$];
  exp_t  qh[$];
  int    cyc = 0;
  int    nvec = 0;
  int    nbad = 0;
  int    hist_m [8];
  int    hist_h [2];
  string cur_req = "R1";
  bit    running = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int gain_of(int code);
    if (code >= 37) return 0;
    return (1024 * (36000 - 994 * code) + 18000) / 36000;
  endfunction

  function automatic int dac(int s);
    return s + 32768 + 64;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 8; i++) hist_m[i] = 0;
    for (int i = 0; i < 2; i++) hist_h[i] = 0;
    qm.delete();
    qh.delete();
  endtask

  task automatic push(int lane, int tag, int s, bit ilv, int now);
    int prev;
    exp_t e;
    prev = (lane == 0) ? hist_m[tag] : hist_h[tag];
    e.tag = tag;
    e.due = now + 2;
    e.word = ilv ? dac((prev + s) >>> 1) : dac(s);
    if (lane == 0) qm.push_back(e); else qh.push_back(e);
    if (ilv) begin
      e.due = now + 3;
      e.word = dac(s);
      if (lane == 0) qm.push_back(e); else qh.push_back(e);
    end
    if (lane == 0) hist_m[tag] = s; else hist_h[tag] = s;
  endtask

  task automatic send(int ch, int smp, bit ilv, int gap);
    int gs, src;
    bit ov;
    gs  = (smp * gain_of(int'(vol_codes[ch*6 +: 6]))) >>> 10;
    ov  = jack_sense && !driver_on;
    src = ov ? 0 : int'(hp_sel);
    push(0, ch, (ov || mute_mask[ch]) ? 0 : gs, ilv, cyc);
    if (ch / 2 == src) push(1, ch % 2, (!ov && mute_mask[8 + ch % 2]) ? 0 : gs, ilv, cyc);
    in_valid  = 1'b1;
    in_chan   = 3'(ch);
    in_sample = 16'(smp);
    interp_en = ilv;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic set_vol(int ch, int code);
    vol_codes[ch*6 +: 6] = 6'(code);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  // Reference comparison on every clock, sampled mid-period.
  always @(negedge clk) begin
    if (running && !rst) begin
      nvec++;
      if (qm.size() > 0 && qm[0].due <= cyc) begin
        if (!out_valid || qm[0].due != cyc || int'(out_chan) != qm[0].tag || int'(out_word) != qm[0].word) begin
          nbad++;
          $display("FAIL %s speaker lane cyc %0d: actual v=%0b ch=%0d w=%0d expected ch=%0d w=%0d",
                   cur_req, cyc, out_valid, out_chan, out_word, qm[0].tag, qm[0].word);
        end
        void'(qm.pop_front());
      end else if (out_valid) begin
        nbad++;
        $display("FAIL %s speaker lane cyc %0d: actual valid w=%0d expected idle", cur_req, cyc, out_word);
      end
      nvec++;
      if (qh.size() > 0 && qh[0].due <= cyc) begin
        if (!hp_valid || qh[0].due != cyc || int'(hp_chan) != qh[0].tag || int'(hp_word) != qh[0].word) begin
          nbad++;
          $display("FAIL %s headphone lane cyc %0d: actual v=%0b ch=%0d w=%0d expected ch=%0d w=%0d",
                   cur_req, cyc, hp_valid, hp_chan, hp_word, qh[0].tag, qh[0].word);
        end
        void'(qh.pop_front());
      end else if (hp_valid) begin
        nbad++;
        $display("FAIL %s headphone lane cyc %0d: actual valid w=%0d expected idle", cur_req, cyc, hp_word);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL R8 watchdog: actual run still busy, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    nvec++;
    if (out_valid || hp_valid || out_word != 0 || hp_word != 0) begin
      nbad++;
      $display("FAIL R1 reset state: actual v=%0b/%0b w=%0d/%0d expected 0/0 0/0",
               out_valid, hp_valid, out_word, hp_word);
    end
    running = 1;
    hp_sel = 2'd3;

    cur_req = "R2";
    send(0, -32768, 0, 0);
    send(0, 32767, 0, 0);
    send(0, 0, 0, 0);
    send(0, -1, 0, 0);
    drain();

    cur_req = "R3";
    set_vol(1, 1);  set_vol(2, 18); set_vol(3, 36); set_vol(4, 10);
    send(1, 20000, 0, 0);
    send(2, -20000, 0, 0);
    send(3, 32767, 0, 0);
    send(4, -32768, 0, 0);
    send(2, 12345, 0, 0);
    drain();

    cur_req = "R4";
    set_vol(5, 37); set_vol(6, 50); set_vol(7, 63);
    send(5, 30000, 0, 0);
    send(6, -30000, 0, 0);
    send(7, 1000, 0, 0);
    drain();

    cur_req = "R5";
    vol_codes = '0;
    mute_mask = 10'b00_1010_0101;
    for (int c = 0; c < 8; c++) send(c, 1000 + 100 * c, 0, 0);
    mute_mask = 10'b00_0101_1010;
    for (int c = 0; c < 8; c++) send(c, -500 - 10 * c, 0, 0);
    drain();

    cur_req = "R6";
    mute_mask = '0;
    set_vol(4, 5);
    for (int p = 0; p < 4; p++) begin
      hp_sel = 2'(p);
      for (int c = 0; c < 8; c++) send(c, 3000 * (c + 1) - 7000, 0, 1);
    end
    mute_mask = 10'b01_0000_0000;
    hp_sel = 2'd2;
    send(4, 9000, 0, 0);
    send(5, -9000, 0, 0);
    drain();

    cur_req = "R7";
    jack_sense = 1'b1; driver_on = 1'b0;
    hp_sel = 2'd3;
    mute_mask = 10'b11_0000_0000;
    for (int c = 0; c < 8; c++) send(c, 4000 - 1500 * c, 0, 0);
    driver_on = 1'b1;
    mute_mask = 10'b00_0000_0001;
    for (int c = 0; c < 8; c++) send(c, 2222 + c, 0, 0);
    jack_sense = 1'b0;
    drain();

    cur_req = "R8";
    mute_mask = '0;
    hp_sel = 2'd1;
    for (int c = 0; c < 8; c++) send(c, -31000 + 7000 * c, 0, 0);
    send(2, 5, 0, 0);
    send(2, 6, 0, 0);
    drain();

    cur_req = "R9";
    hp_sel = 2'd0;
    send(0, 10000, 1, 1);
    send(0, -10001, 1, 1);
    send(1, 32767, 1, 1);
    send(1, -32768, 1, 2);
    send(3, 777, 1, 1);
    drain();

    cur_req = "R10";
    send(2, 8000, 1, 1);
    send(3, -8000, 1, 1);
    send(2, 100, 1, 1);
    send(4, 12000, 0, 0);
    send(4, 0, 1, 1);
    mute_mask = 10'b00_0100_0000;
    send(6, 20000, 0, 0);
    mute_mask = '0;
    send(6, 20000, 1, 1);
    drain();

    cur_req = "R1";
    running = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_model();
    running = 1;
    send(5, 30001, 1, 1);
    send(0, -3, 1, 1);
    drain();

    nvec++;
    if (qm.size() != 0 || qh.size() != 0) begin
      nbad++;
      $display("FAIL R8 leftover expectations: actual %0d/%0d expected 0/0", qm.size(), qh.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule